// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This controller keeps track of which operating mode a device is in and switches it between four run modes and two low-power modes, Halt and Stop. Software asks for a new mode by writing a 4-bit code to a request port. Each mode has its own configuration word, loaded through a simple write port. When a request is legal, the controller loads the target's word and from it drives the clock, regulator, oscillator, PLL and pad-driver enables.

A request for a low-power mode is dropped without any error while an interrupt is pending. For Stop, a pending wakeup also drops it. Codes that name no mode, and transitions that are not allowed, set a sticky error flag, which software clears by writing 1. Any interrupt or wakeup that arrives while the device sits in Halt or Stop returns it to the run mode it left. In Halt, the main regulator stays on when the run mode it left was using the crystal oscillator and the Halt clock setting would otherwise let the regulator drop.

Top module: `lpm_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the outputs hold these values: `cur_mode` = 4'b0100 (Run0), `busy`, `done` and `inv_flag` low, and the enables taken from the reset configuration word 9'h003 (core clock 1, main regulator 1, fast internal oscillator 1, crystal oscillator 0, PLL 0, clock select 0, pad driver 1).
- R2: The run modes are coded 4'b0100 to 4'b0111. A request for any of them, made from a run mode while not busy, raises `busy` on the next edge. On the edge after that, `cur_mode` and all enables are updated, `busy` drops and `done` is high for exactly one cycle.
- R3: Halt is coded 4'b1000 and is accepted only from a run mode. In Halt, `core_clk_en` is low.
- R4: Stop is coded 4'b1010 and is accepted only from a run mode. In Stop, `core_clk_en` is low and `pll_en` is low, whatever the Stop word says.
- R5: A Halt request made while any `irq_pend` bit is set changes nothing. `busy` stays low and `inv_flag` is not set.
- R6: A Stop request made while any `irq_pend` or `wkup_pend` bit is set changes nothing. `busy` stays low and `inv_flag` is not set.
- R7: On entry to Halt, `mvr_en` is forced high when all of these are true: the Halt word has main-regulator 0, fast-oscillator 0 and clock select 2 or 3, and the run mode left had its crystal bit set. Otherwise `mvr_en` follows the Halt word.
- R8: `pad_drv_en` is low only in Stop, and only when the pad power-down bit (bit 8) of the Stop word is set. It is high in every other case.
- R9: `inv_flag` is set by any of these requests: an undefined code, a request while in Halt or Stop, or a request while `busy`. It stays set until `inv_clr` is pulsed. If set and clear fall in the same cycle, set wins.
- R10: Any `irq_pend` or `wkup_pend` bit seen in Halt or Stop raises `busy` on the next edge. On the edge after that, the controller returns to the saved run mode with that mode's current word applied and pulses `done`.
- R11: The layout of the configuration word is: bit 0 main regulator, bit 1 fast oscillator, bit 2 crystal oscillator, bit 3 PLL, bits 7:4 clock select, bit 8 pad power-down. A write to an undefined mode code is ignored. A new word takes effect at the next transition into that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_mode | input | 4 | Mode whose word is written |
| cfg_wdata | input | 9 | Configuration word |
| req_we | input | 1 | Mode request strobe |
| req_mode | input | 4 | Requested mode code |
| inv_clr | input | 1 | Write-1 clear of the invalid flag |
| irq_pend | input | NUM_IRQ | Pending interrupt lines |
| wkup_pend | input | NUM_WKUP | Pending wakeup lines |
| cur_mode | output | 4 | Code of the active mode |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle transition-complete pulse |
| inv_flag | output | 1 | Sticky invalid-request flag |
| core_clk_en | output | 1 | Core clock enable |
| mvr_en | output | 1 | Main regulator enable |
| firc_en | output | 1 | Fast internal oscillator enable |
| xosc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| clk_sel | output | 4 | System clock select |
| pad_drv_en | output | 1 | Pad driver enable |

## Verification
Two things can happen in the same cycle. A mode request can arrive while the device is in Stop, which is an illegal request and sets the flag. In that same cycle an interrupt can arrive, which starts the return to the saved run mode. The bench drives the request strobe and the interrupt on the same edge. It then expects both results one cycle later: `inv_flag` high and `busy` high. On the following edge it expects the saved run mode, not the requested one. A second collision is an undefined code written together with `inv_clr`, where the flag must remain set. A behavioural model also follows every cycle of a long random run in which requests, wakeups and clears overlap freely.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;
  localparam int MODE_W    = 4;
  localparam int CLK_SEL_W = 4;
  localparam int NUM_RUN   = 4;
  localparam int NUM_CFG   = NUM_RUN + 2;
  localparam int CFG_IDX_W = $clog2(NUM_CFG);

  typedef logic [MODE_W-1:0]    mode_t;
  typedef logic [CFG_IDX_W-1:0] cfg_idx_t;

  localparam mode_t MODE_RUN0 = 4'b0100;
  localparam mode_t MODE_HALT = 4'b1000;
  localparam mode_t MODE_STOP = 4'b1010;

  typedef struct packed {
    logic                 pad_pd;
    logic [CLK_SEL_W-1:0] clk_sel;
    logic                 pll_on;
    logic                 xosc_on;
    logic                 firc_on;
    logic                 mvr_on;
  } mode_cfg_t;

  localparam int CFG_W = $bits(mode_cfg_t);

  typedef struct packed {
    logic                 core_clk_en;
    logic                 mvr_en;
    logic                 firc_en;
    logic                 xosc_en;
    logic                 pll_en;
    logic [CLK_SEL_W-1:0] clk_sel;
    logic                 pad_drv_en;
  } pwr_out_t;

  function automatic logic is_run(mode_t m);
    return (m >= MODE_RUN0) && (m < mode_t'(MODE_RUN0 + NUM_RUN));
  endfunction

  function automatic logic is_lowp(mode_t m);
    return (m == MODE_HALT) || (m == MODE_STOP);
  endfunction

  function automatic logic is_defined(mode_t m);
    return is_run(m) || is_lowp(m);
  endfunction

  function automatic cfg_idx_t cfg_index(mode_t m);
    if (is_run(m))        return cfg_idx_t'(m - MODE_RUN0);
    if (m == MODE_HALT)   return cfg_idx_t'(NUM_RUN);
    if (m == MODE_STOP)   return cfg_idx_t'(NUM_RUN + 1);
    return '0;
  endfunction
endpackage

// File: rtl/lpm_cfg_bank.sv
`timescale 1ns/1ps
module lpm_cfg_bank
  import lpm_pkg::*;
#(
  parameter int        ENTRIES  = NUM_CFG,
  parameter mode_cfg_t RST_WORD = '0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  cfg_idx_t  wr_idx,
  input  mode_cfg_t wr_word,
  input  cfg_idx_t  rd_idx,
  output mode_cfg_t rd_word,
  input  cfg_idx_t  xosc_idx,
  output logic      xosc_bit
);
  mode_cfg_t bank [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        bank[e] <= RST_WORD;
      else if (wr_en && wr_idx == cfg_idx_t'(e))
        bank[e] <= wr_word;
    end
  end

  assign rd_word  = bank[rd_idx];
  assign xosc_bit = bank[xosc_idx].xosc_on;
endmodule

// File: rtl/lpm_req_eval.sv
`timescale 1ns/1ps
module lpm_req_eval
  import lpm_pkg::*;
(
  input  logic  req_we,
  input  mode_t req_mode,
  input  mode_t cur_mode,
  input  logic  busy,
  input  logic  irq_any,
  input  logic  wkup_any,
  output logic  accept,
  output logic  invalid
);
  logic legal_ctx;
  logic dropped;

  always_comb begin
    legal_ctx = !busy && is_run(cur_mode);
    invalid   = req_we && (!is_defined(req_mode) || !legal_ctx);
    dropped   = req_we && legal_ctx &&
                (((req_mode == MODE_HALT) && irq_any) ||
                 ((req_mode == MODE_STOP) && (irq_any || wkup_any)));
    accept    = req_we && !invalid && !dropped;
  end
endmodule

// File: rtl/lpm_out_map.sv
`timescale 1ns/1ps
module lpm_out_map
  import lpm_pkg::*;
(
  input  mode_t     mode,
  input  mode_cfg_t cfg,
  input  logic      prev_xosc,
  output pwr_out_t  pwr
);
  logic keep_mvr;

  always_comb begin
    keep_mvr = (mode == MODE_HALT) && !cfg.mvr_on && !cfg.firc_on &&
               ((cfg.clk_sel == CLK_SEL_W'(2)) || (cfg.clk_sel == CLK_SEL_W'(3))) &&
               prev_xosc;
    pwr.core_clk_en = is_run(mode);
    pwr.mvr_en      = cfg.mvr_on | keep_mvr;
    pwr.firc_en     = cfg.firc_on;
    pwr.xosc_en     = cfg.xosc_on;
    pwr.pll_en      = (mode == MODE_STOP) ? 1'b0 : cfg.pll_on;
    pwr.clk_sel     = cfg.clk_sel;
    pwr.pad_drv_en  = !((mode == MODE_STOP) && cfg.pad_pd);
  end
endmodule

// File: rtl/lpm_ctrl.sv
`timescale 1ns/1ps
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int               NUM_IRQ   = 8,
  parameter int               NUM_WKUP  = 4,
  parameter logic [CFG_W-1:0] CFG_RESET = 9'h003
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [MODE_W-1:0]    cfg_mode,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic                 req_we,
  input  logic [MODE_W-1:0]    req_mode,
  input  logic                 inv_clr,
  input  logic [NUM_IRQ-1:0]   irq_pend,
  input  logic [NUM_WKUP-1:0]  wkup_pend,
  output logic [MODE_W-1:0]    cur_mode,
  output logic                 busy,
  output logic                 done,
  output logic                 inv_flag,
  output logic                 core_clk_en,
  output logic                 mvr_en,
  output logic                 firc_en,
  output logic                 xosc_en,
  output logic                 pll_en,
  output logic [CLK_SEL_W-1:0] clk_sel,
  output logic                 pad_drv_en
);
  localparam mode_cfg_t RST_CFG = mode_cfg_t'(CFG_RESET);
  localparam pwr_out_t  RST_PWR = '{core_clk_en: 1'b1,
                                    mvr_en:      RST_CFG.mvr_on,
                                    firc_en:     RST_CFG.firc_on,
                                    xosc_en:     RST_CFG.xosc_on,
                                    pll_en:      RST_CFG.pll_on,
                                    clk_sel:     RST_CFG.clk_sel,
                                    pad_drv_en:  1'b1};

  mode_t     cur_q, tgt_q, prev_q;
  logic      busy_q, done_q, inv_q;
  pwr_out_t  pwr_q, pwr_next;
  mode_cfg_t tgt_cfg;
  logic      prev_xosc;
  logic      irq_any, wkup_any, wake;
  logic      accept, invalid;

  assign irq_any  = |irq_pend;
  assign wkup_any = |wkup_pend;
  assign wake     = !busy_q && is_lowp(cur_q) && (irq_any || wkup_any);

  lpm_cfg_bank #(.ENTRIES(NUM_CFG), .RST_WORD(RST_CFG)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we && is_defined(cfg_mode)),
    .wr_idx   (cfg_index(cfg_mode)),
    .wr_word  (mode_cfg_t'(cfg_wdata)),
    .rd_idx   (cfg_index(tgt_q)),
    .rd_word  (tgt_cfg),
    .xosc_idx (cfg_index(prev_q)),
    .xosc_bit (prev_xosc)
  );

  lpm_req_eval u_eval (
    .req_we   (req_we),
    .req_mode (req_mode),
    .cur_mode (cur_q),
    .busy     (busy_q),
    .irq_any  (irq_any),
    .wkup_any (wkup_any),
    .accept   (accept),
    .invalid  (invalid)
  );

  lpm_out_map u_map (
    .mode      (tgt_q),
    .cfg       (tgt_cfg),
    .prev_xosc (prev_xosc),
    .pwr       (pwr_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= MODE_RUN0;
      tgt_q  <= MODE_RUN0;
      prev_q <= MODE_RUN0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      inv_q  <= 1'b0;
      pwr_q  <= RST_PWR;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        cur_q  <= tgt_q;
        pwr_q  <= pwr_next;
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (wake) begin
        tgt_q  <= prev_q;
        busy_q <= 1'b1;
      end else if (accept) begin
        tgt_q  <= req_mode;
        busy_q <= 1'b1;
        if (is_lowp(req_mode)) prev_q <= cur_q;
      end
      if (invalid)      inv_q <= 1'b1;
      else if (inv_clr) inv_q <= 1'b0;
    end
  end

  assign cur_mode    = cur_q;
  assign busy        = busy_q;
  assign done        = done_q;
  assign inv_flag    = inv_q;
  assign core_clk_en = pwr_q.core_clk_en;
  assign mvr_en      = pwr_q.mvr_en;
  assign firc_en     = pwr_q.firc_en;
  assign xosc_en     = pwr_q.xosc_en;
  assign pll_en      = pwr_q.pll_en;
  assign clk_sel     = pwr_q.clk_sel;
  assign pad_drv_en  = pwr_q.pad_drv_en;
endmodule

// File: rtl/lpm_ctrl_chk.sv
`timescale 1ns/1ps
module lpm_ctrl_chk
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int NUM_WKUP = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                req_we,
  input logic [MODE_W-1:0]   req_mode,
  input logic                inv_clr,
  input logic [NUM_IRQ-1:0]  irq_pend,
  input logic [NUM_WKUP-1:0] wkup_pend,
  input logic [MODE_W-1:0]   cur_mode,
  input logic                busy,
  input logic                done,
  input logic                inv_flag,
  input logic                core_clk_en,
  input logic                pll_en
);
  assert_busy_single_R2: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy && done));

  assert_mode_change_done_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_mode) |-> done);

  assert_core_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && is_lowp(cur_mode)) |-> !core_clk_en);

  assert_stop_pll_off_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && cur_mode == MODE_STOP) |-> !pll_en);

  assert_halt_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (req_we && !busy && is_run(cur_mode) && req_mode == MODE_HALT && (|irq_pend))
    |=> !busy);

  assert_stop_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (req_we && !busy && is_run(cur_mode) && req_mode == MODE_STOP &&
     ((|irq_pend) || (|wkup_pend))) |=> !busy);

  assert_inv_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (inv_flag && !inv_clr) |=> inv_flag);

  assert_wake_start_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && is_lowp(cur_mode) && ((|irq_pend) || (|wkup_pend))) |=> busy);
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .NUM_WKUP(NUM_WKUP)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_we      (req_we),
  .req_mode    (req_mode),
  .inv_clr     (inv_clr),
  .irq_pend    (irq_pend),
  .wkup_pend   (wkup_pend),
  .cur_mode    (cur_mode),
  .busy        (busy),
  .done        (done),
  .inv_flag    (inv_flag),
  .core_clk_en (core_clk_en),
  .pll_en      (pll_en)
);

// File: tb/lpm_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpm_ctrl_tb_top;
  localparam int NI = 8;
  localparam int NW = 4;
  localparam logic [3:0] RUN0 = 4'b0100, RUN1 = 4'b0101, RUN2 = 4'b0110,
                         RUN3 = 4'b0111, HALT = 4'b1000, STOP = 4'b1010;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, cfg_we = 1'b0, req_we = 1'b0, inv_clr = 1'b0;
  logic [3:0] cfg_mode = '0, req_mode = '0;
  logic [8:0] cfg_wdata = '0;
  logic [NI-1:0] irq_pend = '0;
  logic [NW-1:0] wkup_pend = '0;
  logic [3:0] cur_mode, clk_sel;
  logic busy, done, inv_flag, core_clk_en, mvr_en, firc_en, xosc_en, pll_en, pad_drv_en;

  lpm_ctrl #(.NUM_IRQ(NI), .NUM_WKUP(NW)) dut_i (.*);

  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 0, finished = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [8:0] m_cfg [6];
  logic [3:0] m_cur, m_tgt, m_prev, m_clk;
  logic m_busy, m_done, m_inv, m_core, m_mvr, m_firc, m_xosc, m_pll, m_pad;

  function automatic int idx(input logic [3:0] m);
    if (m >= 4 && m <= 7) return int'(m) - 4;
    if (m == HALT) return 4;
    if (m == STOP) return 5;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 6; i++) m_cfg[i] = 9'h003;
    m_cur = RUN0; m_tgt = RUN0; m_prev = RUN0;
    m_busy = 0; m_done = 0; m_inv = 0;
    m_core = 1; m_mvr = 1; m_firc = 1; m_xosc = 0; m_pll = 0; m_clk = 0; m_pad = 1;
  endtask

  task automatic model_apply(input logic [3:0] m);
    logic [8:0] c;
    c = m_cfg[idx(m)];
    m_core = (idx(m) < 4);
    m_mvr  = c[0] | ((m == HALT) && !c[0] && !c[1] && (c[7:4] == 2 || c[7:4] == 3)
                     && m_cfg[idx(m_prev)][2]);
    m_firc = c[1]; m_xosc = c[2]; m_clk = c[7:4];
    m_pll  = (m == STOP) ? 1'b0 : c[3];
    m_pad  = !((m == STOP) && c[8]);
  endtask

  initial model_reset();

  always @(posedge clk) begin
    logic inval, anyi, anyw, lowp;
    if (rst) model_reset();
    else begin
      anyi  = |irq_pend;
      anyw  = |wkup_pend;
      lowp  = (m_cur == HALT) || (m_cur == STOP);
      inval = req_we && (idx(req_mode) < 0 || m_busy || lowp);
      m_done = 0;
      if (m_busy) begin
        model_apply(m_tgt);
        m_cur = m_tgt; m_busy = 0; m_done = 1;
      end else if (lowp && (anyi || anyw)) begin
        m_tgt = m_prev; m_busy = 1;
      end else if (req_we && !inval &&
                   !((req_mode == HALT && anyi) || (req_mode == STOP && (anyi || anyw)))) begin
        if (req_mode == HALT || req_mode == STOP) m_prev = m_cur;
        m_tgt = req_mode; m_busy = 1;
      end
      if (inval) m_inv = 1;
      else if (inv_clr) m_inv = 0;
      if (cfg_we && idx(cfg_mode) >= 0) m_cfg[idx(cfg_mode)] = cfg_wdata;
    end
  end

  always @(negedge clk) if (cmp_on) begin
    chk("R2 cur_mode vs model", 16'(cur_mode), 16'(m_cur));
    chk("R2 busy vs model", 16'(busy), 16'(m_busy));
    chk("R2 done vs model", 16'(done), 16'(m_done));
    chk("R9 inv_flag vs model", 16'(inv_flag), 16'(m_inv));
    chk("R3 core_clk_en vs model", 16'(core_clk_en), 16'(m_core));
    chk("R7 mvr_en vs model", 16'(mvr_en), 16'(m_mvr));
    chk("R4 pll_en vs model", 16'(pll_en), 16'(m_pll));
    chk("R8 pad_drv_en vs model", 16'(pad_drv_en), 16'(m_pad));
    chk("R11 firc/xosc/clk_sel vs model", {10'd0, firc_en, xosc_en, clk_sel},
        {10'd0, m_firc, m_xosc, m_clk});
  end

  task automatic step(); @(negedge clk); endtask

  task automatic req(input logic [3:0] m);
    step(); req_we = 1; req_mode = m;
    step(); req_we = 0;
  endtask

  task automatic wcfg(input logic [3:0] m, input logic [8:0] d);
    step(); cfg_we = 1; cfg_mode = m; cfg_wdata = d;
    step(); cfg_we = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (5) step();
    rst = 0;
    step();
    // R1 reset state
    chk("R1 cur_mode", 16'(cur_mode), 16'(RUN0));
    chk("R1 busy/done/inv", {busy, done, inv_flag}, 0);
    chk("R1 enables", {core_clk_en, mvr_en, firc_en, xosc_en, pll_en, clk_sel, pad_drv_en},
        16'b1_1_1_0_0_0000_1);
    cmp_on = 1;

    wcfg(RUN1, 9'h04F);   // R11: mvr, firc, xosc, pll on, clk 4
    wcfg(HALT, 9'h028);   // pll on, clk 2, mvr/firc off
    wcfg(STOP, 9'h138);   // pad power-down, clk 3, pll on
    req(RUN1);
    chk("R2 busy after request", 16'(busy), 1);
    step();
    chk("R2 cur_mode Run1", 16'(cur_mode), 16'(RUN1));
    chk("R2 done pulse", 16'(done), 1);
    chk("R11 crystal enable from Run1 word", 16'(xosc_en), 1);
    step();
    chk("R2 done single cycle", 16'(done), 0);

    irq_pend = 8'h10;
    req(HALT);
    chk("R5 halt dropped busy", 16'(busy), 0);
    chk("R5 halt dropped no flag", 16'(inv_flag), 0);
    irq_pend = 0;
    req(HALT);
    step();
    chk("R3 in Halt", 16'(cur_mode), 16'(HALT));
    chk("R3 core clock frozen", 16'(core_clk_en), 0);
    chk("R7 regulator kept on", 16'(mvr_en), 1);
    wkup_pend = 4'h2;
    step(); wkup_pend = 0;
    chk("R10 wake busy", 16'(busy), 1);
    step();
    chk("R10 back to Run1", 16'(cur_mode), 16'(RUN1));
    chk("R10 pll reapplied", 16'(pll_en), 1);

    wkup_pend = 4'h1;
    req(STOP);
    chk("R6 stop dropped busy", 16'(busy), 0);
    chk("R6 stop dropped no flag", 16'(inv_flag), 0);
    wkup_pend = 0;
    req(STOP);
    step();
    chk("R4 in Stop", 16'(cur_mode), 16'(STOP));
    chk("R4 pll forced off", 16'(pll_en), 0);
    chk("R8 pad driver off", 16'(pad_drv_en), 0);

    // collision: illegal request in Stop together with an interrupt
    step(); req_we = 1; req_mode = RUN0; irq_pend = 8'h01;
    step(); req_we = 0; irq_pend = 0;
    chk("R9 request in Stop flags", 16'(inv_flag), 1);
    chk("R10 wake started", 16'(busy), 1);
    step();
    chk("R10 saved mode not requested", 16'(cur_mode), 16'(RUN1));
    chk("R8 pad driver back on", 16'(pad_drv_en), 1);

    step(); inv_clr = 1;
    step(); inv_clr = 0;
    chk("R9 cleared", 16'(inv_flag), 0);
    step(); req_we = 1; req_mode = 4'b0011; inv_clr = 1;
    step(); req_we = 0; inv_clr = 0;
    chk("R9 set wins over clear", 16'(inv_flag), 1);
    chk("R9 undefined not started", 16'(busy), 0);
    step(); inv_clr = 1;
    step(); inv_clr = 0;

    step(); req_we = 1; req_mode = RUN2;
    step(); req_mode = RUN3;
    step(); req_we = 0;
    chk("R9 request while busy", 16'(inv_flag), 1);
    chk("R9 busy request ignored", 16'(cur_mode), 16'(RUN2));
    step(); inv_clr = 1;
    step(); inv_clr = 0;

    wcfg(4'b1111, 9'h1FF);
    req(RUN0);
    step();
    chk("R11 undefined write ignored", {12'd0, clk_sel}, 0);
    req(HALT);
    step();
    chk("R7 no crystal before Halt", 16'(mvr_en), 0);
    irq_pend = 8'h80;
    step(); irq_pend = 0;
    step();
    chk("R10 back to Run0", 16'(cur_mode), 16'(RUN0));

    wcfg(STOP, 9'h038);
    req(STOP);
    step();
    chk("R8 pad on without power-down bit", 16'(pad_drv_en), 1);
    wkup_pend = 4'h8;
    step(); wkup_pend = 0;
    repeat (2) step();

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] codes [10];
      codes = '{RUN0, RUN1, RUN2, RUN3, HALT, STOP, HALT, STOP, 4'h0, 4'hF};
      step();
      req_we    = ($urandom_range(0, 5) == 0);
      req_mode  = codes[$urandom_range(0, 9)];
      irq_pend  = ($urandom_range(0, 9) == 0) ? NI'(1) << $urandom_range(0, NI - 1) : '0;
      wkup_pend = ($urandom_range(0, 11) == 0) ? NW'(1) << $urandom_range(0, NW - 1) : '0;
      inv_clr   = ($urandom_range(0, 15) == 0);
      cfg_we    = ($urandom_range(0, 15) == 0);
      cfg_mode  = codes[$urandom_range(0, 9)];
      cfg_wdata = 9'($urandom);
    end
    step();
    req_we = 0; irq_pend = 0; wkup_pend = 0; inv_clr = 0; cfg_we = 0;
    repeat (4) step();
    summary();
  end
endmodule